// File: doc/BRIEF.md
# Data-Ready Triggered ADC Frame Reader

This block is the SPI master for a multi-channel delta-sigma converter. When asked to configure, it pulses chip select high and then low. With chip select held low it shifts out a reset opcode, then a bulk register-write opcode, then one byte for each configuration register. The register bytes come from a flat image vector that is captured when the request arrives. The serial clock is fixed to mode 0: it idles low, MOSI changes on falling edges and MISO is sampled on rising edges.

Once configured, a start request raises the converter's start pin and arms the reader. From then on, every falling edge of the active-low data-ready input, after synchronisation, triggers one 32-clock read with chip select low. The first byte read is a status byte and the next three form a 24-bit sample, most significant byte first. Status and sample are presented together on a valid/ready output. A stop request drops the start pin, abandons any read in progress and ignores further data-ready edges. Two sticky flags report trouble: one for a data-ready edge that arrives during a read, one for an unaccepted sample that was overwritten.

Top module: `adc_frame_reader`

## Requirements
- R1: The serial clock is low whenever chip select (active low) is high, and the reset state has chip select high, serial clock low, MOSI low, the start pin low, sample valid low and both flags clear.
- R2: After a configure request, chip select stays high for at least 2*CLK_HALF cycles and then goes low. It stays low for exactly (NUM_REGS+2)*8 rising serial clock edges, during which MOSI carries RST_CMD, WRITE_CMD, then register byte 0 (bits 7:0 of the image) through register byte NUM_REGS-1, each byte MSB first, changing only on falling edges.
- R3: A read frame starts only on a high-to-low transition of the data-ready input while the reader is armed. Holding that input low does not start another frame.
- R4: A read frame keeps chip select low for exactly 32 rising serial clock edges, with MOSI held at 0 throughout.
- R5: The first 8 bits received in a frame appear on the status output, and the remaining 24 bits appear on the sample output with the first received bit as bit 23.
- R6: The start pin goes high after a start request and stays high until a stop request.
- R7: A stop request ends any frame in progress at once: chip select goes high, no sample is delivered, and later data-ready edges start no frame.
- R8: A data-ready falling edge during a read frame sets the sticky overrun flag and does not start an extra frame.
- R9: If a frame completes while a sample is valid and not accepted, the new sample replaces the old one and the sticky overflow flag is set.
- R10: A valid sample stays valid and unchanged until it is accepted with ready, unless R9 replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgReq | input | 1 | Pulse: run the configuration sequence |
| startReq | input | 1 | Pulse: begin conversions and arm the reader |
| stopReq | input | 1 | Pulse: end streaming |
| regImage | input | NUM_REGS*8 | Register values; byte i belongs to register i |
| sclk | output | 1 | Serial clock, mode 0 |
| csN | output | 1 | Chip select, active low |
| adcStart | output | 1 | Converter start pin |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |
| drdyN | input | 1 | Converter data-ready, active low, asynchronous |
| sampleValid | output | 1 | Status and sample are valid |
| sampleReady | input | 1 | Consumer accepts the sample |
| sampleStatus | output | 8 | Status byte of the frame |
| sampleData | output | 24 | Assembled 24-bit sample |
| overrun | output | 1 | Sticky: data-ready edge arrived during a frame |
| overflow | output | 1 | Sticky: unaccepted sample overwritten |

## Verification
The bench holds data-ready low well after a frame has finished. A reader that triggered on level instead of edge would start a second frame, and the chip-select fall count would go up. It also lets a second data-ready fall arrive in the middle of a frame. A wrong design would either restart the transfer, which gives a corrupted sample and extra clocks, or drop the overrun flag. Stalling ready across two frames shows whether the held sample stays stable and whether the overwrite is flagged. A stop issued in the middle of a frame catches a design that finishes the frame or delivers a stray sample. Comparing the configuration byte order on MOSI catches a reversed register image or swapped opcodes.

// File: rtl/adc_rdr_pkg.sv
package adc_rdr_pkg;

  localparam int FRAME_BITS = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_CFG,
    ST_READY,
    ST_WAIT,
    ST_READ
  } rdrState_t;

  // strobes from control to datapath, acted on at the next clock edge
  typedef struct packed {
    logic latchImage;
    logic goCfg;
    logic goRead;
    logic abort;
    logic publish;
  } rdrStrobe_t;

endpackage

// File: rtl/adc_rdr_datapath.sv
module adc_rdr_datapath
  import adc_rdr_pkg::*;
#(
  parameter int unsigned CLK_HALF  = 2,
  parameter int unsigned NUM_REGS  = 10,
  parameter logic [7:0]  RST_CMD   = 8'hC0,
  parameter logic [7:0]  WRITE_CMD = 8'h70
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rdrStrobe_t            strobe,
  input  logic [NUM_REGS*8-1:0] regImage,
  input  logic                  miso,
  input  logic                  sampleReady,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  xferDone,
  output logic                  xferBusy,
  output logic                  sampleValid,
  output logic [7:0]            sampleStatus,
  output logic [23:0]           sampleData,
  output logic                  overflow
);

  localparam int CFG_BITS = (NUM_REGS + 2) * 8;
  localparam int MAX_BITS = (CFG_BITS > FRAME_BITS) ? CFG_BITS : FRAME_BITS;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam int DIV_W    = $clog2(CLK_HALF + 1);
  localparam int TX_W     = MAX_BITS;

  logic [NUM_REGS*8-1:0] imageQ;
  logic [TX_W-1:0]       cfgWord;
  logic [TX_W-1:0]       txShift;
  logic [FRAME_BITS-1:0] rxShift;
  logic [CNT_W-1:0]      bitsLeft;
  logic [DIV_W-1:0]      divCnt;
  logic                  sclkQ;
  logic                  active;

  // configuration word: opcodes first, then register 0 upward
  assign cfgWord[TX_W-1 -: 8]  = RST_CMD;
  assign cfgWord[TX_W-9 -: 8]  = WRITE_CMD;
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_img
    assign cfgWord[TX_W-17-gi*8 -: 8] = imageQ[gi*8 +: 8];
  end
  if (TX_W > CFG_BITS) begin : g_pad
    assign cfgWord[TX_W-CFG_BITS-1:0] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) imageQ <= '0;
    else if (strobe.latchImage) imageQ <= regImage;
  end

  // bit engine: low phase, rising edge samples, high phase, falling edge shifts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      sclkQ    <= 1'b0;
      divCnt   <= '0;
      bitsLeft <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      xferDone <= 1'b0;
    end else begin
      xferDone <= 1'b0;
      if (strobe.abort) begin
        active  <= 1'b0;
        sclkQ   <= 1'b0;
        divCnt  <= '0;
        txShift <= '0;
      end else if (strobe.goCfg) begin
        active   <= 1'b1;
        sclkQ    <= 1'b0;
        divCnt   <= '0;
        bitsLeft <= CNT_W'(CFG_BITS);
        txShift  <= cfgWord;
      end else if (strobe.goRead) begin
        active   <= 1'b1;
        sclkQ    <= 1'b0;
        divCnt   <= '0;
        bitsLeft <= CNT_W'(FRAME_BITS);
        txShift  <= '0;
      end else if (active) begin
        if (divCnt == DIV_W'(CLK_HALF - 1)) begin
          divCnt <= '0;
          if (!sclkQ) begin
            sclkQ   <= 1'b1;
            rxShift <= {rxShift[FRAME_BITS-2:0], miso};
          end else begin
            sclkQ    <= 1'b0;
            txShift  <= {txShift[TX_W-2:0], 1'b0};
            bitsLeft <= bitsLeft - CNT_W'(1);
            if (bitsLeft == CNT_W'(1)) begin
              active   <= 1'b0;
              xferDone <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign sclk     = sclkQ;
  assign mosi     = txShift[TX_W-1];
  assign xferBusy = active;

  // output holding register with overwrite-on-stall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleValid  <= 1'b0;
      sampleStatus <= '0;
      sampleData   <= '0;
      overflow     <= 1'b0;
    end else begin
      if (strobe.publish) begin
        if (sampleValid && !sampleReady) overflow <= 1'b1;
        sampleValid  <= 1'b1;
        sampleStatus <= rxShift[31:24];
        sampleData   <= rxShift[23:0];
      end else if (sampleValid && sampleReady) begin
        sampleValid <= 1'b0;
      end
    end
  end

  // R10: a held sample does not move until accepted or replaced
  a_r10_sample_held: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && !sampleReady && !strobe.publish
      |=> sampleValid && $stable(sampleData) && $stable(sampleStatus));

  // R9: overflow never clears once set
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R4: a read transfer never carries a one on MOSI
  a_r4_read_mosi_low: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.goRead) |-> !mosi);

endmodule

// File: rtl/adc_rdr_control.sv
module adc_rdr_control
  import adc_rdr_pkg::*;
#(
  parameter int unsigned CLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgReq,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       drdyN,
  input  logic       xferDone,
  output rdrStrobe_t strobe,
  output logic       csN,
  output logic       adcStart,
  output logic       overrun
);

  localparam int GAP_CYC = 2 * CLK_HALF;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  rdrState_t  state, nextState;
  logic [GAP_W-1:0] gapCnt;
  logic drdyMeta, drdySync, drdyPrev, drdyFall;

  // two-flop synchroniser plus edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drdyMeta <= 1'b1;
      drdySync <= 1'b1;
      drdyPrev <= 1'b1;
    end else begin
      drdyMeta <= drdyN;
      drdySync <= drdyMeta;
      drdyPrev <= drdySync;
    end
  end
  assign drdyFall = drdyPrev && !drdySync;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (cfgReq) begin
        strobe.latchImage = 1'b1;
        nextState = ST_GAP;
      end
      ST_GAP: if (gapCnt == GAP_W'(GAP_CYC - 1)) begin
        strobe.goCfg = 1'b1;
        nextState = ST_CFG;
      end
      ST_CFG: if (xferDone) nextState = ST_READY;
      ST_READY: begin
        if (cfgReq) begin
          strobe.latchImage = 1'b1;
          nextState = ST_GAP;
        end else if (startReq) begin
          nextState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (stopReq) begin
          nextState = ST_READY;
        end else if (drdyFall) begin
          strobe.goRead = 1'b1;
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        if (stopReq) begin
          strobe.abort = 1'b1;
          nextState = ST_READY;
        end else if (xferDone) begin
          strobe.publish = 1'b1;
          nextState = ST_WAIT;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gapCnt   <= '0;
      csN      <= 1'b1;
      adcStart <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      state    <= nextState;
      gapCnt   <= (state == ST_GAP) ? gapCnt + GAP_W'(1) : '0;
      csN      <= !(nextState == ST_CFG || nextState == ST_READ);
      adcStart <= (nextState == ST_WAIT || nextState == ST_READ);
      if (state == ST_READ && drdyFall) overrun <= 1'b1;
    end
  end

  // R3: a read frame opens only right after a synchronised falling edge
  a_r3_frame_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) && adcStart |-> $past(drdyFall));

  // R8: overrun never clears once set
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R7: a stop while armed releases chip select and the start pin
  a_r7_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    stopReq && (state == ST_WAIT || state == ST_READ) |=> csN && !adcStart);

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rdr_pkg::*;
#(
  parameter int unsigned CLK_HALF  = 2,
  parameter int unsigned NUM_REGS  = 10,
  parameter logic [7:0]  RST_CMD   = 8'hC0,
  parameter logic [7:0]  WRITE_CMD = 8'h70
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgReq,
  input  logic                  startReq,
  input  logic                  stopReq,
  input  logic [NUM_REGS*8-1:0] regImage,
  output logic                  sclk,
  output logic                  csN,
  output logic                  adcStart,
  output logic                  mosi,
  input  logic                  miso,
  input  logic                  drdyN,
  output logic                  sampleValid,
  input  logic                  sampleReady,
  output logic [7:0]            sampleStatus,
  output logic [23:0]           sampleData,
  output logic                  overrun,
  output logic                  overflow
);

  rdrStrobe_t strobe;
  logic xferDone;
  logic xferBusy;

  adc_rdr_control #(.CLK_HALF(CLK_HALF)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgReq   (cfgReq),
    .startReq (startReq),
    .stopReq  (stopReq),
    .drdyN    (drdyN),
    .xferDone (xferDone),
    .strobe   (strobe),
    .csN      (csN),
    .adcStart (adcStart),
    .overrun  (overrun)
  );

  adc_rdr_datapath #(
    .CLK_HALF (CLK_HALF),
    .NUM_REGS (NUM_REGS),
    .RST_CMD  (RST_CMD),
    .WRITE_CMD(WRITE_CMD)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regImage    (regImage),
    .miso        (miso),
    .sampleReady (sampleReady),
    .sclk        (sclk),
    .mosi        (mosi),
    .xferDone    (xferDone),
    .xferBusy    (xferBusy),
    .sampleValid (sampleValid),
    .sampleStatus(sampleStatus),
    .sampleData  (sampleData),
    .overflow    (overflow)
  );

  // R1: serial clock idles low outside chip select
  a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R2: the bit engine only runs with chip select asserted
  a_r2_busy_under_cs: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy |-> !csN);

endmodule

// File: tb/tb_adc_frame_reader.sv
`timescale 1ns/1ps
module tb_adc_frame_reader;

  localparam int NREG = 10;
  localparam int HALF = 2;
  localparam logic [7:0] RSTC = 8'hC0;
  localparam logic [7:0] WRC  = 8'h70;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgReq = 1'b0, startReq = 1'b0, stopReq = 1'b0;
  logic [NREG*8-1:0] regImage = '0;
  logic sclk, csN, adcStart, mosi, miso;
  logic drdyN = 1'b1;
  logic sampleValid, sampleReady = 1'b1;
  logic [7:0] sampleStatus;
  logic [23:0] sampleData;
  logic overrun, overflow;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  adc_frame_reader #(.CLK_HALF(HALF), .NUM_REGS(NREG), .RST_CMD(RSTC), .WRITE_CMD(WRC)) dut (
    .clk(clk), .rstN(rstN), .cfgReq(cfgReq), .startReq(startReq), .stopReq(stopReq),
    .regImage(regImage), .sclk(sclk), .csN(csN), .adcStart(adcStart), .mosi(mosi),
    .miso(miso), .drdyN(drdyN), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .sampleStatus(sampleStatus), .sampleData(sampleData), .overrun(overrun), .overflow(overflow));

  // converter model
  logic [31:0]  frameWord = '0;
  logic [31:0]  modelShift = '0;
  logic [127:0] mosiLog = '0;
  int edgeCnt = 0;
  int csFalls = 0;
  int csHighRun = 0;
  int lastGap = 0;

  assign miso = modelShift[31];
  always @(negedge csN) begin
    modelShift = frameWord;
    edgeCnt = 0;
    mosiLog = '0;
    csFalls++;
  end
  always @(posedge sclk) if (!csN) begin
    edgeCnt++;
    mosiLog = {mosiLog[126:0], mosi};
  end
  always @(negedge sclk) if (!csN) modelShift = {modelShift[30:0], 1'b0};
  always @(posedge clk) begin
    if (csN) csHighRun++;
    else begin
      if (csHighRun != 0) lastGap = csHighRun;
      csHighRun = 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] expCfg(input logic [NREG*8-1:0] img);
    logic [127:0] w;
    w = 128'(RSTC);
    w = (w << 8) | 128'(WRC);
    for (int i = 0; i < NREG; i++) w = (w << 8) | 128'(img[i*8 +: 8]);
    return w;
  endfunction

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic waitValid();
    do @(negedge clk); while (!sampleValid);
  endtask

  task automatic readFrame(input logic [31:0] w);
    frameWord = w;
    @(negedge clk) drdyN = 1'b0;
    waitValid();
    check(sampleStatus == w[31:24], "R5 status", 128'(sampleStatus), 128'(w[31:24]));
    check(sampleData == w[23:0], "R5 data", 128'(sampleData), 128'(w[23:0]));
    check(edgeCnt == 32, "R4 clock count", 128'(edgeCnt), 128'd32);
    check(mosiLog[31:0] == 32'd0, "R4 mosi zero", mosiLog, 128'd0);
    repeat (4) @(negedge clk);
    drdyN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int falls0;
    int validSeen;
    logic [31:0] wa, wb;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(csN == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 reset pins", {csN, sclk, mosi}, 3'b100);
    check(adcStart == 1'b0 && sampleValid == 1'b0 && overrun == 1'b0 && overflow == 1'b0,
          "R1 reset outputs", {adcStart, sampleValid, overrun, overflow}, 4'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 configuration, two rounds with random images
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < NREG; i++) regImage[i*8 +: 8] = 8'($urandom);
      pulse(cfgReq);
      regImage = '0;               // image must have been latched
      @(negedge csN);
      @(posedge csN);
      check(edgeCnt == (NREG + 2) * 8, "R2 config clocks", 128'(edgeCnt), 128'((NREG + 2) * 8));
      check(lastGap >= 2 * HALF, "R2 cs toggle gap", 128'(lastGap), 128'(2 * HALF));
      repeat (5) @(negedge clk);
    end
    for (int i = 0; i < NREG; i++) regImage[i*8 +: 8] = 8'(i * 17 + 3);
    pulse(cfgReq);
    @(negedge csN);
    @(posedge csN);
    check(mosiLog == expCfg(regImage), "R2 config bytes", mosiLog, expCfg(regImage));
    repeat (5) @(negedge clk);

    // R3/R7: edge before start is ignored
    falls0 = csFalls;
    drdyN = 1'b0;
    repeat (40) @(negedge clk);
    drdyN = 1'b1;
    repeat (10) @(negedge clk);
    check(csFalls == falls0, "R7 idle edge ignored", 128'(csFalls), 128'(falls0));

    pulse(startReq);
    @(negedge clk);
    check(adcStart == 1'b1, "R6 start pin", 128'(adcStart), 128'd1);

    // main stream: directed corners then random words
    readFrame(32'hFFFF_FFFF);
    readFrame(32'h8000_0001);
    for (int k = 0; k < 6; k++) readFrame($urandom);

    // R3: level held low must not retrigger
    falls0 = csFalls;
    frameWord = $urandom;
    @(negedge clk) drdyN = 1'b0;
    repeat (400) @(negedge clk);
    check(csFalls == falls0 + 1, "R3 level no retrigger", 128'(csFalls), 128'(falls0 + 1));
    drdyN = 1'b1;
    repeat (10) @(negedge clk);
    check(adcStart == 1'b1, "R6 start held", 128'(adcStart), 128'd1);

    // R10 / R9: stall the consumer
    sampleReady = 1'b0;
    wa = $urandom;
    wb = $urandom;
    frameWord = wa;
    @(negedge clk) drdyN = 1'b0;
    waitValid();
    repeat (60) @(negedge clk);
    drdyN = 1'b1;
    check(sampleValid && sampleData == wa[23:0], "R10 held sample", 128'(sampleData), 128'(wa[23:0]));
    check(overflow == 1'b0, "R9 no early overflow", 128'(overflow), 128'd0);
    frameWord = wb;
    repeat (6) @(negedge clk);
    drdyN = 1'b0;
    @(negedge csN);
    @(posedge csN);
    repeat (3) @(negedge clk);
    check(sampleData == wb[23:0] && sampleStatus == wb[31:24], "R9 overwrite",
          128'({sampleStatus, sampleData}), 128'(wb));
    check(overflow == 1'b1, "R9 overflow flag", 128'(overflow), 128'd1);
    sampleReady = 1'b1;
    repeat (2) @(negedge clk);
    check(sampleValid == 1'b0, "R10 accept clears", 128'(sampleValid), 128'd0);
    drdyN = 1'b1;
    repeat (10) @(negedge clk);

    // R8: second edge in the middle of a frame
    check(overrun == 1'b0, "R8 no early overrun", 128'(overrun), 128'd0);
    falls0 = csFalls;
    wa = $urandom;
    frameWord = wa;
    @(negedge clk) drdyN = 1'b0;
    repeat (30) @(negedge clk);
    drdyN = 1'b1;
    repeat (10) @(negedge clk);
    frameWord = ~wa;
    drdyN = 1'b0;
    waitValid();
    check(sampleData == wa[23:0], "R8 frame intact", 128'(sampleData), 128'(wa[23:0]));
    check(overrun == 1'b1, "R8 overrun flag", 128'(overrun), 128'd1);
    check(csFalls == falls0 + 1, "R8 single frame", 128'(csFalls), 128'(falls0 + 1));
    repeat (4) @(negedge clk);
    drdyN = 1'b1;
    repeat (10) @(negedge clk);

    // R7: stop in the middle of a frame
    falls0 = csFalls;
    frameWord = $urandom;
    @(negedge clk) drdyN = 1'b0;
    repeat (60) @(negedge clk);
    pulse(stopReq);
    check(csN == 1'b1 && sclk == 1'b0, "R7 abort cs", {csN, sclk}, 2'b10);
    check(adcStart == 1'b0, "R6 start dropped", 128'(adcStart), 128'd0);
    validSeen = 0;
    drdyN = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (sampleValid) validSeen++;
      if (k == 100) drdyN = 1'b0;
      if (k == 150) drdyN = 1'b1;
      if (k == 200) drdyN = 1'b0;
    end
    check(validSeen == 0, "R7 no sample after stop", 128'(validSeen), 128'd0);
    check(csFalls == falls0 + 1, "R7 edges ignored", 128'(csFalls), 128'(falls0 + 1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule